// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the status byte of a serial memory device and decides whether a write may proceed. It holds the software write-enable latch, a non-volatile lock-enable bit that arms the hardware protect pin, and a two-bit block-protect code that fences off an upper part of the array. A command engine drives set, clear and status-write strobes. A write sequencer supplies a busy level and a one-cycle done pulse. The block returns the byte that a status read must shift out, together with two permits: one for an array write at a given start address and one for a status write.

A status write that is granted is held pending. Its lock-enable and block-protect bits take effect only on the sequencer's done pulse. Until then a status read shows ones in every position except busy. Serial shifting and write timing belong to the surrounding logic.

Top module: `sr_guard`

## Requirements
- R1: Outside status programming, `sts_o` is {lock-enable (bit 7), 3'b000 (bits 6..4), block code (bits 3..2), write enable (bit 1), `busy_i` (bit 0)}.
- R2: After reset the write-enable latch, lock-enable bit and block code are all 0, so `sts_o` reads 0x00 with `busy_i` low.
- R3: `wel_set_i` sets the write-enable latch on the next edge. `wel_clr_i` clears it, and the clear wins when both strobes arrive together.
- R4: A `wdone_i` pulse clears the write-enable latch on the next edge.
- R5: When `wp_n_i` is 0 and the lock-enable bit is 1, `sr_wr_ok_o` is 0. A status-write strobe is then refused: status bits and write enable stay unchanged.
- R6: When the lock-enable bit is 0, `wp_n_i` has no effect on `sr_wr_ok_o`.
- R7: Block code 00 fences nothing. Code 01 fences addresses 0x6000..0x7FFF, code 10 fences 0x4000..0x7FFF, and code 11 fences the whole array. `arr_wr_ok_o` is 0 for a fenced address.
- R8: Both permits require write enable 1, `busy_i` 0 and no status programming pending. A refused array write leaves write enable unchanged.
- R9: A granted status write copies only data bits 7, 3 and 2 into lock-enable and the block code. All other data bits are ignored.
- R10: From the edge that grants a status write until the next `wdone_i` edge, `sts_o` reads 7'h7F in bits 7..1 and `busy_i` in bit 0.
- R11: The lock-enable and block bits change only on a `wdone_i` edge that ends status programming, not when the write is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wel_set_i | input | 1 | Set write-enable strobe |
| wel_clr_i | input | 1 | Clear write-enable strobe |
| sr_wr_i | input | 1 | Status-write strobe |
| sr_wdata_i | input | 8 | Status byte offered with the strobe |
| wp_n_i | input | 1 | Hardware protect pin, low asserts |
| busy_i | input | 1 | Write cycle in progress |
| wdone_i | input | 1 | One-cycle pulse at the end of a write cycle |
| wr_addr_i | input | ADDR_W | Start address of a proposed array write |
| sts_o | output | 8 | Status byte as read back |
| arr_wr_ok_o | output | 1 | Array write permitted at `wr_addr_i` |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
The assertions assume that `wdone_i` is a single-cycle pulse and that `busy_i` stays high from a granted write until that pulse. They also assume `sr_wr_i` is raised only when the command engine has decoded a status write. The stimulus follows this sequencer behaviour: after every grant it raises busy, holds it for some cycles, pulses done once and then drops busy. It toggles the protect pin only between commands. A reference model in the bench tracks the latch and the pending bits and predicts each cycle's outputs.

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_wdata_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic              wdone_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [7:0]        sts_o,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o
);

  logic       wel_q, wpen_q, prog_q, pend_wpen_q;
  logic [1:0] bp_q, pend_bp_q;
  logic       hw_lock, addr_fenced, idle_ok, sr_take;
  logic       unused_bits;

  assign unused_bits = ^{sr_wdata_i[6:4], sr_wdata_i[1:0]};

  assign hw_lock = ~wp_n_i & wpen_q;
  assign idle_ok = wel_q & ~busy_i & ~prog_q;

  always_comb begin
    case (bp_q)
      2'b00:   addr_fenced = 1'b0;
      2'b01:   addr_fenced = &wr_addr_i[ADDR_W-1 -: 2];
      2'b10:   addr_fenced = wr_addr_i[ADDR_W-1];
      default: addr_fenced = 1'b1;
    endcase
  end

  assign arr_wr_ok_o = idle_ok & ~addr_fenced;
  assign sr_wr_ok_o  = idle_ok & ~hw_lock;
  assign sr_take     = sr_wr_i & sr_wr_ok_o;

  assign sts_o = prog_q ? {7'h7F, busy_i}
                        : {wpen_q, 3'b000, bp_q, wel_q, busy_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wel_q <= 1'b0;
    else if (wdone_i || wel_clr_i)  wel_q <= 1'b0;
    else if (wel_set_i)             wel_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q      <= 1'b0;
      pend_wpen_q <= 1'b0;
      pend_bp_q   <= 2'b00;
      wpen_q      <= 1'b0;
      bp_q        <= 2'b00;
    end else if (sr_take) begin
      prog_q      <= 1'b1;
      pend_wpen_q <= sr_wdata_i[7];
      pend_bp_q   <= sr_wdata_i[3:2];
    end else if (wdone_i && prog_q) begin
      prog_q <= 1'b0;
      wpen_q <= pend_wpen_q;
      bp_q   <= pend_bp_q;
    end
  end

endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wel_set_i,
  input logic       wel_clr_i,
  input logic       wp_n_i,
  input logic       wdone_i,
  input logic [7:0] sts_o,
  input logic       arr_wr_ok_o,
  input logic       sr_wr_ok_o,
  input logic       wel_q,
  input logic       wpen_q,
  input logic       prog_q,
  input logic [1:0] bp_q
);

  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wdone_i |=> !wel_q);

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_i |=> !wel_q);

  a_r3_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (wel_set_i && !wel_clr_i && !wdone_i) |=> wel_q);

  a_r5_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n_i && wpen_q) |-> !sr_wr_ok_o);

  a_r7_all_fenced: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_q == 2'b11) |-> !arr_wr_ok_o);

  a_r8_need_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_ok_o || sr_wr_ok_o) |-> wel_q);

  a_r11_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdone_i && prog_q) |=> $stable({wpen_q, bp_q}));

  a_r10_prog_ones: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |-> (sts_o[7:1] == 7'h7F));

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_q |-> (sts_o[6:4] == 3'b000));

endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wel_set_i  (wel_set_i),
  .wel_clr_i  (wel_clr_i),
  .wp_n_i     (wp_n_i),
  .wdone_i    (wdone_i),
  .sts_o      (sts_o),
  .arr_wr_ok_o(arr_wr_ok_o),
  .sr_wr_ok_o (sr_wr_ok_o),
  .wel_q      (wel_q),
  .wpen_q     (wpen_q),
  .prog_q     (prog_q),
  .bp_q       (bp_q)
);

// File: tb/sr_guard_tb.sv
`timescale 1ns/1ps
module sr_guard_tb;

  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_s = 0, clr_s = 0, req_s = 0, wp_n = 1, busy = 0, done = 0;
  logic [7:0]    wd = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0]    sts;
  logic          arr_ok, sr_ok;

  always #10 clk = ~clk;

  sr_guard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wel_set_i(set_s), .wel_clr_i(clr_s),
    .sr_wr_i(req_s), .sr_wdata_i(wd), .wp_n_i(wp_n), .busy_i(busy),
    .wdone_i(done), .wr_addr_i(addr), .sts_o(sts), .arr_wr_ok_o(arr_ok),
    .sr_wr_ok_o(sr_ok));

  typedef struct {
    logic [7:0] sts;
    logic       arr;
    logic       sr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  logic       m_wel = 0, m_wpen = 0, m_prog = 0, m_pwpen = 0;
  logic [1:0] m_bp = 0, m_pbp = 0;

  function automatic logic fenced(input logic [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 15'h6000;
      2'b10:   return a >= 15'h4000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic drive(input logic s, input logic c, input logic r,
                       input logic [7:0] d, input logic wpn, input logic b,
                       input logic dn, input logic [AW-1:0] a, input string tag);
    exp_t e;
    logic ok_idle;
    @(negedge clk);
    set_s = s; clr_s = c; req_s = r; wd = d; wp_n = wpn; busy = b; done = dn; addr = a;
    ok_idle = m_wel && !b && !m_prog;
    e.sts = m_prog ? {7'h7F, b} : {m_wpen, 3'b000, m_bp, m_wel, b};
    e.arr = ok_idle && !fenced(m_bp, a);
    e.sr  = ok_idle && !(!wpn && m_wpen);
    e.tag = tag;
    exp_q.push_back(e);
    if (r && e.sr) begin
      m_prog = 1; m_pwpen = d[7]; m_pbp = d[3:2];
    end else if (dn && m_prog) begin
      m_prog = 0; m_wpen = m_pwpen; m_bp = m_pbp;
    end
    if (dn || c) m_wel = 0;
    else if (s) m_wel = 1;
  endtask

  task automatic idle(input logic wpn, input logic [AW-1:0] a, input string tag);
    drive(0, 0, 0, 8'h00, wpn, 0, 0, a, tag);
  endtask

  task automatic program_sr(input logic [7:0] d, input logic wpn, input string tag);
    drive(1, 0, 0, 8'h00, wpn, 0, 0, '0, "R3");
    drive(0, 0, 1, d, wpn, 0, 0, '0, tag);
    drive(0, 0, 0, 8'h00, wpn, 1, 0, '0, "R10");
    drive(0, 0, 0, 8'h00, wpn, 1, 0, '0, "R10");
    drive(0, 0, 0, 8'h00, wpn, 1, 1, '0, "R4");
    drive(0, 0, 0, 8'h00, wpn, 0, 0, '0, "R11");
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (sts !== e.sts || arr_ok !== e.arr || sr_ok !== e.sr) begin
          errors++;
          $display("FAIL %s: sts=%h arr=%b sr=%b expected sts=%h arr=%b sr=%b",
                   e.tag, sts, arr_ok, sr_ok, e.sts, e.arr, e.sr);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    rst_n = 1;
    idle(1, '0, "R2");
    idle(1, '0, "R1");
    drive(0, 0, 0, 8'h00, 1, 0, 0, 15'h0010, "R8");
    drive(1, 0, 0, 8'h00, 1, 0, 0, '0, "R3");
    idle(1, 15'h7FFF, "R3");
    drive(1, 1, 0, 8'h00, 1, 0, 0, '0, "R3");
    idle(1, '0, "R3");
    drive(1, 0, 0, 8'h00, 1, 0, 0, '0, "R3");
    drive(0, 0, 0, 8'h00, 1, 1, 0, 15'h0100, "R8");
    drive(0, 0, 0, 8'h00, 1, 0, 0, 15'h0100, "R8");
    drive(0, 0, 0, 8'h00, 1, 1, 1, '0, "R4");
    idle(1, '0, "R4");
    program_sr(8'hFF, 1, "R9");
    idle(1, '0, "R9");
    drive(1, 0, 0, 8'h00, 1, 0, 0, '0, "R3");
    idle(1, 15'h0000, "R7");
    drive(0, 0, 0, 8'h00, 0, 0, 0, '0, "R5");
    drive(0, 0, 1, 8'h00, 0, 0, 0, '0, "R5");
    idle(0, '0, "R5");
    idle(0, '0, "R5");
    program_sr(8'h04, 1, "R6");
    idle(0, '0, "R6");
    drive(1, 0, 0, 8'h00, 0, 0, 0, '0, "R3");
    idle(0, 15'h5FFF, "R7");
    idle(0, 15'h6000, "R7");
    idle(0, 15'h7FFF, "R7");
    program_sr(8'h78, 0, "R6");
    drive(1, 0, 0, 8'h00, 1, 0, 0, '0, "R3");
    idle(1, 15'h3FFF, "R7");
    idle(1, 15'h4000, "R7");
    drive(0, 0, 1, 8'h73, 1, 0, 0, '0, "R9");
    idle(1, '0, "R10");
    drive(0, 0, 0, 8'h00, 1, 1, 1, '0, "R11");
    idle(1, '0, "R11");
    drive(1, 0, 0, 8'h00, 1, 0, 0, '0, "R3");
    idle(1, 15'h7FFF, "R7");
    idle(1, 15'h0000, "R7");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule